// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is a small on-chip debug sequencer. It walks through three working states toward a terminal Final state. It moves in response to four single-cycle match events that come from external comparators. Each working state has its own 4-bit routing code. The code says which match channel moves the sequencer, and to which state. This lets a debugger describe an ordered chain of events, for example "address A, then B, then C", that ends in a trigger.

Software loads the three routing codes through a small write port while the sequencer is idle. It then raises the arm input. The sequencer starts in State1 and follows the codes. When it reaches Final it emits a one-cycle trigger pulse and stays in Final until it is disarmed and armed again. Each match channel counts only while its enable input is set. When several enabled matches arrive in the same cycle, a match routed to Final wins over all others. Otherwise the lowest-numbered channel that has an effect wins.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset `state_o` reads 0 (idle), `trig_o` is low and all three routing codes are 0000.
- R2: In idle with `arm_i` high, the sequencer enters State1 at the next clock. While `arm_i` is low, it returns to idle at the next clock from any state.
- R3: A write with `wr_en_i` high loads `wr_code_i` into the code of State1, State2 or State3 when `wr_sel_i` is 1, 2 or 3. The write takes effect only while `state_o` is idle. A write while armed, or with `wr_sel_i` = 0, leaves every code unchanged.
- R4: A match on channel n counts only when bit n of `match_en_i` is set in the same cycle.
- R5: State1 codes: 1: M0→S2. 2: M1→S3. 3: M2→S3. 4: M3→S3. 5: M0→S2, M1→S3. 6: M0→S2, M2→S3. 7: M1→S2, M3→S3. 8: M0→Final. 9: M1→S3, M0→Final. 10: M2→S3, M0→Final. 11: M3→S3, M1→Final. 12: any→S2. 13: any→S3. Unlisted channels have no effect.
- R6: State2 codes: 1: M0→S1. 2: M1→S3. 3: M2→Final. 4: M3→S3. 5: any→S1. 6: any→S3. 7: M0/M1/M2→S3, M3 no effect. 8: M0→S3, M1→Final. 9: M2→S1, M3→Final.
- R7: State3 codes: 1 to 4: channel (code−1)→Final. 5: any→Final. 6: any→S1. 7: M0→S2, M1→Final.
- R8: Some codes are reserved: 0, 14 and 15 in State1; 0 and 10–15 in State2; 0 and 8–15 in State3. Under a reserved code no match causes a transition.
- R9: When several counted matches arrive together, one routed to Final is taken first. Otherwise the lowest-numbered channel with an effect decides the next state.
- R10: On entry to Final, `trig_o` is high for exactly one cycle. Final then holds against further matches until `arm_i` goes low.
- R11: `state_o` encodes idle=0, State1=1, State2=2, State3=3, Final=4. A transition appears one clock after the match cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm level; low disarms |
| match_i | input | 4 | Single-cycle match pulses, channels 0..3 |
| match_en_i | input | 4 | Per-channel comparator enables |
| wr_en_i | input | 1 | Routing code write strobe |
| wr_sel_i | input | 2 | Target code: 1..3 = State1..State3 |
| wr_code_i | input | 4 | Code value to write |
| state_o | output | 3 | Current sequencer state |
| armed_o | output | 1 | High whenever state is not idle |
| trig_o | output | 1 | One-cycle pulse on entry to Final |

## Verification
The assertions assume that match inputs are one-cycle pulses sampled at the clock. They also assume that the write port is driven only between clock edges. The bench drives all inputs on the falling edge and keeps every match pulse to one cycle. It pulses matches only after the sequencer has settled in the state under test. Writes are issued in idle, except for the one that deliberately probes the armed lock.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;
  localparam int unsigned ST_W   = 3;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_FIN  = 3'd4
  } seq_state_e;

  // Target of one channel under a state's code; ST_IDLE means "no effect".
  function automatic seq_state_e route(seq_state_e st, logic [CODE_W-1:0] code, int ch);
    seq_state_e r;
    r = ST_IDLE;
    unique case (st)
      ST_S1: begin
        case (code)
          4'd1:  if (ch == 0) r = ST_S2;
          4'd2:  if (ch == 1) r = ST_S3;
          4'd3:  if (ch == 2) r = ST_S3;
          4'd4:  if (ch == 3) r = ST_S3;
          4'd5:  begin if (ch == 0) r = ST_S2; if (ch == 1) r = ST_S3; end
          4'd6:  begin if (ch == 0) r = ST_S2; if (ch == 2) r = ST_S3; end
          4'd7:  begin if (ch == 1) r = ST_S2; if (ch == 3) r = ST_S3; end
          4'd8:  if (ch == 0) r = ST_FIN;
          4'd9:  begin if (ch == 1) r = ST_S3; if (ch == 0) r = ST_FIN; end
          4'd10: begin if (ch == 2) r = ST_S3; if (ch == 0) r = ST_FIN; end
          4'd11: begin if (ch == 3) r = ST_S3; if (ch == 1) r = ST_FIN; end
          4'd12: r = ST_S2;
          4'd13: r = ST_S3;
          default: r = ST_IDLE;
        endcase
      end
      ST_S2: begin
        case (code)
          4'd1: if (ch == 0) r = ST_S1;
          4'd2: if (ch == 1) r = ST_S3;
          4'd3: if (ch == 2) r = ST_FIN;
          4'd4: if (ch == 3) r = ST_S3;
          4'd5: r = ST_S1;
          4'd6: r = ST_S3;
          4'd7: if (ch != 3) r = ST_S3;
          4'd8: begin if (ch == 0) r = ST_S3; if (ch == 1) r = ST_FIN; end
          4'd9: begin if (ch == 2) r = ST_S1; if (ch == 3) r = ST_FIN; end
          default: r = ST_IDLE;
        endcase
      end
      ST_S3: begin
        case (code)
          4'd1: if (ch == 0) r = ST_FIN;
          4'd2: if (ch == 1) r = ST_FIN;
          4'd3: if (ch == 2) r = ST_FIN;
          4'd4: if (ch == 3) r = ST_FIN;
          4'd5: r = ST_FIN;
          4'd6: r = ST_S1;
          4'd7: begin if (ch == 0) r = ST_S2; if (ch == 1) r = ST_FIN; end
          default: r = ST_IDLE;
        endcase
      end
      default: r = ST_IDLE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dbgseq_code_regs.sv
module dbgseq_code_regs
  import dbgseq_pkg::*;
#(
  parameter int unsigned N_REGS = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           armed_i,
  input  logic                           wr_en_i,
  input  logic [SEL_W-1:0]               wr_sel_i,
  input  logic [CODE_W-1:0]              wr_code_i,
  output logic [N_REGS-1:0][CODE_W-1:0]  code_o
);
  logic [N_REGS-1:0][CODE_W-1:0] code_q;

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic ld;
    assign ld = wr_en_i && !armed_i && (wr_sel_i == SEL_W'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  code_q[g] <= '0;
      else if (ld) code_q[g] <= wr_code_i;
    end
  end

  assign code_o = code_q;

  // R3: armed sequencer must see frozen codes
  a_r3_locked_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    armed_i |=> $stable(code_q));
endmodule

// File: rtl/dbgseq_route.sv
module dbgseq_route
  import dbgseq_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned N_REGS = 3
) (
  input  seq_state_e                       state_i,
  input  logic [N_REGS-1:0][CODE_W-1:0]    code_i,
  input  logic [N_CH-1:0]                  eff_i,
  output logic [N_CH-1:0][ST_W-1:0]        tgt_o,
  output logic [N_CH-1:0]                  hit_o,
  output logic [N_CH-1:0]                  fin_o
);
  logic [CODE_W-1:0] cur_code;

  always_comb begin
    cur_code = '0;
    if (state_i == ST_S1) cur_code = code_i[0];
    if (state_i == ST_S2) cur_code = code_i[1];
    if (state_i == ST_S3) cur_code = code_i[2];
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    seq_state_e t;
    assign t        = route(state_i, cur_code, g);
    assign tgt_o[g] = t;
    assign hit_o[g] = eff_i[g] && (t != ST_IDLE);
    assign fin_o[g] = eff_i[g] && (t == ST_FIN);
  end
endmodule

// File: rtl/dbgseq_pick.sv
module dbgseq_pick
  import dbgseq_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  logic [N_CH-1:0][ST_W-1:0] tgt_i,
  input  logic [N_CH-1:0]           hit_i,
  input  logic [N_CH-1:0]           fin_i,
  output logic                      valid_o,
  output logic [ST_W-1:0]           tgt_o
);
  always_comb begin
    valid_o = 1'b0;
    tgt_o   = ST_IDLE;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        valid_o = 1'b1;
        tgt_o   = tgt_i[i];
      end
    end
    if (|fin_i) tgt_o = ST_FIN;
  end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbgseq_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned N_REGS = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [N_CH-1:0]   match_i,
  input  logic [N_CH-1:0]   match_en_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [CODE_W-1:0] wr_code_i,
  output logic [ST_W-1:0]   state_o,
  output logic              armed_o,
  output logic              trig_o
);
  seq_state_e                     state_q, state_nx;
  logic                           trig_q, trig_nx;
  logic [N_CH-1:0]                eff;
  logic [N_REGS-1:0][CODE_W-1:0]  codes;
  logic [N_CH-1:0][ST_W-1:0]      tgts;
  logic [N_CH-1:0]                hits, fins;
  logic                           pick_vld;
  logic [ST_W-1:0]                pick_tgt;
  logic                           working;

  assign eff     = match_i & match_en_i;
  assign working = (state_q == ST_S1) || (state_q == ST_S2) || (state_q == ST_S3);

  dbgseq_code_regs #(.N_REGS(N_REGS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .armed_i(armed_o), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_code_i(wr_code_i), .code_o(codes));

  dbgseq_route #(.N_CH(N_CH), .N_REGS(N_REGS)) u_route (
    .state_i(state_q), .code_i(codes), .eff_i(eff),
    .tgt_o(tgts), .hit_o(hits), .fin_o(fins));

  dbgseq_pick #(.N_CH(N_CH)) u_pick (
    .tgt_i(tgts), .hit_i(hits), .fin_i(fins), .valid_o(pick_vld), .tgt_o(pick_tgt));

  always_comb begin
    state_nx = state_q;
    if (!arm_i)                          state_nx = ST_IDLE;
    else if (state_q == ST_IDLE)         state_nx = ST_S1;
    else if (working && pick_vld)        state_nx = seq_state_e'(pick_tgt);
    trig_nx = (state_nx == ST_FIN) && (state_q != ST_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      trig_q  <= trig_nx;
    end
  end

  assign state_o = state_q;
  assign armed_o = (state_q != ST_IDLE);
  assign trig_o  = trig_q;

  a_r2_disarm_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> state_o == ST_IDLE);
  a_r2_arm_to_s1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE && arm_i) |=> state_o == ST_S1);
  a_r8_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (working && arm_i && !(|eff)) |=> $stable(state_o));
  a_r10_final_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_FIN && arm_i) |=> state_o == ST_FIN);
  a_r10_trig_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);
  a_r10_trig_in_final: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> state_o == ST_FIN);
  a_r11_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= ST_FIN);
endmodule

// File: tb/dbg_trig_seq_bench.sv
module dbg_trig_seq_bench;
  localparam time TCK = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm_i = 1'b0;
  logic [3:0] match_i = '0;
  logic [3:0] match_en_i = 4'hF;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [3:0] wr_code_i = '0;
  logic [2:0] state_o;
  logic       armed_o, trig_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCK/2) clk = ~clk;

  dbg_trig_seq u_dbg_trig_seq (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .match_i(match_i),
    .match_en_i(match_en_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_code_i(wr_code_i), .state_o(state_o), .armed_o(armed_o), .trig_o(trig_o));

  // {start state, code, match mask, expected next state}
  localparam int NV = 27;
  localparam logic [12:0] VEC [NV] = '{
    {2'd1, 4'd1,  4'b0001, 3'd2}, {2'd1, 4'd1,  4'b0010, 3'd1},
    {2'd1, 4'd5,  4'b0011, 3'd2}, {2'd1, 4'd5,  4'b0010, 3'd3},
    {2'd1, 4'd11, 4'b1010, 3'd4}, {2'd1, 4'd7,  4'b1010, 3'd2},
    {2'd1, 4'd12, 4'b1000, 3'd2}, {2'd1, 4'd13, 4'b0100, 3'd3},
    {2'd1, 4'd14, 4'b1111, 3'd1}, {2'd1, 4'd0,  4'b1111, 3'd1},
    {2'd1, 4'd8,  4'b0001, 3'd4}, {2'd1, 4'd10, 4'b0101, 3'd4},
    {2'd2, 4'd7,  4'b1000, 3'd2}, {2'd2, 4'd7,  4'b0100, 3'd3},
    {2'd2, 4'd3,  4'b0100, 3'd4}, {2'd2, 4'd3,  4'b0011, 3'd2},
    {2'd2, 4'd9,  4'b1100, 3'd4}, {2'd2, 4'd9,  4'b0100, 3'd1},
    {2'd2, 4'd11, 4'b1111, 3'd2}, {2'd2, 4'd5,  4'b1000, 3'd1},
    {2'd2, 4'd8,  4'b0011, 3'd4},
    {2'd3, 4'd5,  4'b0010, 3'd4}, {2'd3, 4'd7,  4'b0011, 3'd4},
    {2'd3, 4'd7,  4'b0001, 3'd2}, {2'd3, 4'd8,  4'b1111, 3'd3},
    {2'd3, 4'd6,  4'b0100, 3'd1}, {2'd3, 4'd4,  4'b0111, 3'd3}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] code);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_code_i = code;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    match_i = m;
    @(negedge clk);
    match_i = '0;
  endtask

  task automatic disarm();
    @(negedge clk);
    arm_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic arm();
    @(negedge clk);
    arm_i = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(TCK * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 / R11: reset state
    #(TCK * 3);
    @(negedge clk);
    chk("R1 state", state_o, 0);
    chk("R1 trig", trig_o, 0);
    chk("R11 armed", armed_o, 0);
    rst_n = 1'b1;
    // R1: codes reset to 0000 -> reserved, matches do nothing in State1
    arm();
    chk("R2 armed enters S1", state_o, 1);
    pulse(4'hF);
    chk("R1 reset code reserved", state_o, 1);

    // Table walk: R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [1:0] st; logic [3:0] cd, mk; logic [2:0] ex;
      string tag;
      {st, cd, mk, ex} = VEC[i];
      tag = (st == 2'd1) ? "R5" : (st == 2'd2) ? "R6" : "R7";
      disarm();
      if (st == 2'd1) wr(2'd1, cd);
      if (st == 2'd2) begin wr(2'd1, 4'd12); wr(2'd2, cd); end
      if (st == 2'd3) begin wr(2'd1, 4'd13); wr(2'd3, cd); end
      arm();
      if (st != 2'd1) pulse(4'b0001);
      chk({tag, " setup"}, state_o, st);
      pulse(mk);
      chk({tag, "/R8/R9 next state"}, state_o, ex);
      chk("R10 trig on entry", trig_o, (ex == 3'd4) ? 1 : 0);
      @(negedge clk);
      chk("R10 trig drops", trig_o, 0);
    end

    // R3: write while armed is ignored
    disarm();
    wr(2'd1, 4'd1);
    arm();
    wr(2'd1, 4'd0);
    wr(2'd0, 4'd0);
    pulse(4'b0001);
    chk("R3 armed write ignored", state_o, 2);
    // R3: sel 0 changes nothing
    disarm();
    wr(2'd0, 4'd14);
    arm();
    pulse(4'b0001);
    chk("R3 sel0 ignored", state_o, 2);

    // R4: disabled channel does not count
    disarm();
    wr(2'd1, 4'd1);
    arm();
    match_en_i = 4'b1110;
    pulse(4'b0001);
    chk("R4 disabled match", state_o, 1);
    match_en_i = 4'b0001;
    pulse(4'b0001);
    chk("R4 enabled match", state_o, 2);
    match_en_i = 4'hF;

    // R10: Final holds; R2 disarm and rearm
    disarm();
    wr(2'd1, 4'd8);
    arm();
    pulse(4'b0001);
    chk("R10 reach final", state_o, 4);
    chk("R10 trig", trig_o, 1);
    pulse(4'hF);
    chk("R10 final held", state_o, 4);
    chk("R10 no retrigger", trig_o, 0);
    @(negedge clk);
    arm_i = 1'b0;
    @(negedge clk);
    chk("R2 disarm to idle", state_o, 0);
    chk("R2 armed low", armed_o, 0);
    arm_i = 1'b1;
    @(negedge clk);
    chk("R2 rearm to S1", state_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule